// File: doc/BRIEF.md
# In-Order Dual-Pipe Store Buffer

This block sits between two store-issue pipelines and one memory write port. Every store carries a sequence tag that the core assigns in program order. Memory stores wait in a small queue kept for each pipeline. A drain stage sends them to the memory port one at a time, always taking the older of the two queue heads, so writes reach memory in the order the core generated them, whichever pipe issued them.

I/O stores never enter a queue. An I/O store is held at its issue port until both queues are empty and the memory port is idle. It then goes straight to the port, flagged as I/O, so it cannot overtake an earlier memory store. A younger memory store on the other pipe waits behind an older pending I/O store.

A core that must order later work after its buffered stores (an I/O access, a locked access or a serializing step) raises a sync request. The acknowledge is given only while nothing is buffered and nothing is outstanding on the memory port. The requester drops the request when it sees the acknowledge, so the acknowledge lasts one cycle.

Top module: `ordered_store_buffer`

## Requirements
- R1: After reset the memory port shows no valid write, both queues are empty, and both issue ports are ready for a memory store.
- R2: Stores leave the memory port in ascending tag order across both pipes. A tag x is older than a tag y when the top bit of (x - y), taken modulo 2^SW, is set. An older store presented on one pipe is never overtaken by a younger store from the other pipe.
- R3: Each pipeline queue holds DEPTH entries, and the port register holds one more. While a pipe's queue is full, that pipe's ready is low for a memory store.
- R4: An I/O store is accepted only when both queues are empty, the memory port holds no write, and the other pipe presents no older store. On the next cycle it appears on the port with m_io high.
- R5: While m_valid is high and m_ready is low, the port's tag, address, data and I/O flag stay unchanged.
- R6: sync_ack is high exactly in the cycles where sync_req is high, both queues are empty and m_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Pipe A store present |
| a_ready | output | 1 | Pipe A store accepted this cycle if valid |
| a_addr | input | AW | Pipe A store address |
| a_data | input | DW | Pipe A store data |
| a_seq | input | SW | Pipe A program-order tag |
| a_io | input | 1 | Pipe A store targets I/O space |
| b_valid | input | 1 | Pipe B store present |
| b_ready | output | 1 | Pipe B store accepted this cycle if valid |
| b_addr | input | AW | Pipe B store address |
| b_data | input | DW | Pipe B store data |
| b_seq | input | SW | Pipe B program-order tag |
| b_io | input | 1 | Pipe B store targets I/O space |
| m_valid | output | 1 | Memory write present |
| m_ready | input | 1 | Memory accepts the write |
| m_addr | output | AW | Write address |
| m_data | output | DW | Write data |
| m_tag | output | SW | Tag of the write |
| m_io | output | 1 | Write is an I/O store |
| sync_req | input | 1 | Request to wait for all buffered stores |
| sync_ack | output | 1 | All buffered stores have completed |

## Verification
The bench sweeps pipe-assignment patterns, I/O densities and memory back-pressure patterns, and checks every write against the tag order. A design that drained one queue blindly would emit a younger pipe-A write ahead of an older pipe-B write. A design that let I/O bypass too early would put an I/O write ahead of buffered memory writes. Separate tests fill pipe A against a stalled port and expect exactly DEPTH+1 accepted stores: an off-by-one full flag would accept one store too many or one too few. A sync request raised during that stall must see no acknowledge until the fifth write drains, so an acknowledge taken from the queues alone would arrive while a write is still outstanding.

// File: rtl/ordered_store_buffer.sv
module ordered_store_buffer #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int SW    = 6,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  input  logic [SW-1:0] a_seq,
  input  logic          a_io,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_data,
  input  logic [SW-1:0] b_seq,
  input  logic          b_io,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_data,
  output logic [SW-1:0] m_tag,
  output logic          m_io,
  input  logic          sync_req,
  output logic          sync_ack
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = SW + AW + DW;

  function automatic logic older(input logic [SW-1:0] x, input logic [SW-1:0] y);
    logic [SW-1:0] d;
    d = x - y;
    return d[SW-1];
  endfunction

  logic [1:0]    v, io, rdy, push, pop, io_go, can, full, empty, pres_old, blk;
  logic [SW-1:0] sq [2];
  logic [SW-1:0] hsq [2];
  logic [EW-1:0] din [2];
  logic [EW-1:0] head [2];
  logic [EW-1:0] mem [2][DEPTH];
  logic [PW-1:0] rp [2];
  logic [PW-1:0] wp [2];
  logic [PW:0]   cnt [2];
  logic          idle, load_ok, sel;

  assign v      = {b_valid, a_valid};
  assign io     = {b_io, a_io};
  assign sq[0]  = a_seq;
  assign sq[1]  = b_seq;
  assign din[0] = {a_seq, a_addr, a_data};
  assign din[1] = {b_seq, b_addr, b_data};

  assign idle    = (&empty) && !m_valid;
  assign load_ok = !m_valid || m_ready;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      empty[i]    = (cnt[i] == '0);
      full[i]     = (cnt[i] == (PW+1)'(DEPTH));
      head[i]     = mem[i][rp[i]];
      hsq[i]      = head[i][EW-1 -: SW];
      pres_old[i] = v[1-i] && older(sq[1-i], sq[i]);
      blk[i]      = v[1-i] && io[1-i] && older(sq[1-i], sq[i]);
      rdy[i]      = io[i] ? (idle && !pres_old[i]) : (!full[i] && !blk[i]);
      can[i]      = !empty[i] &&
                    (!empty[1-i] || !(v[1-i] && !io[1-i] && older(sq[1-i], hsq[i])));
    end
  end

  assign push  = v & ~io & rdy;
  assign io_go = v & io & rdy;
  assign sel   = can[1] && (!can[0] || older(hsq[1], hsq[0]));
  assign pop[0] = load_ok && !(|io_go) && can[0] && !sel;
  assign pop[1] = load_ok && !(|io_go) && can[1] && sel;

  assign a_ready  = rdy[0];
  assign b_ready  = rdy[1];
  assign sync_ack = sync_req && idle;

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++)
      if (push[i]) mem[i][wp[i]] <= din[i];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        rp[i]  <= '0;
        wp[i]  <= '0;
        cnt[i] <= '0;
      end else begin
        if (push[i]) wp[i] <= (wp[i] == PW'(DEPTH-1)) ? '0 : wp[i] + 1'b1;
        if (pop[i])  rp[i] <= (rp[i] == PW'(DEPTH-1)) ? '0 : rp[i] + 1'b1;
        cnt[i] <= cnt[i] + (PW+1)'(push[i]) - (PW+1)'(pop[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_io    <= 1'b0;
      {m_tag, m_addr, m_data} <= '0;
    end else if (|io_go) begin
      m_valid <= 1'b1;
      m_io    <= 1'b1;
      {m_tag, m_addr, m_data} <= io_go[0] ? din[0] : din[1];
    end else if (|pop) begin
      m_valid <= 1'b1;
      m_io    <= 1'b0;
      {m_tag, m_addr, m_data} <= pop[0] ? head[0] : head[1];
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

module ordered_store_buffer_chk #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int SW    = 6,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_valid,
  input logic          a_ready,
  input logic          a_io,
  input logic          b_valid,
  input logic          b_ready,
  input logic          b_io,
  input logic          m_valid,
  input logic          m_ready,
  input logic [AW-1:0] m_addr,
  input logic [DW-1:0] m_data,
  input logic [SW-1:0] m_tag,
  input logic          m_io,
  input logic          sync_ack,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1
);
  logic [SW-1:0] last;
  logic          seen;
  logic [SW-1:0] back;
  assign back = last - m_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      last <= '0;
    end else if (m_valid && m_ready) begin
      seen <= 1'b1;
      last <= m_tag;
    end
  end

  // R2
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && seen) |-> back[SW-1]);

  // R3
  depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 <= CW'(DEPTH)) && (cnt1 <= CW'(DEPTH)));

  // R3
  full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == CW'(DEPTH) && !a_io) |-> !a_ready);

  // R4
  io_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_valid && a_ready && a_io) || (b_valid && b_ready && b_io)) |-> (!m_valid && cnt0 == '0 && cnt1 == '0));

  // R4
  io_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_valid && a_ready && a_io) || (b_valid && b_ready && b_io)) |=> (m_valid && m_io));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_tag) && $stable(m_addr) && $stable(m_data) && $stable(m_io)));

  // R6
  sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ack |-> (!m_valid && cnt0 == '0 && cnt1 == '0));
endmodule

bind ordered_store_buffer ordered_store_buffer_chk #(
  .AW(AW), .DW(DW), .SW(SW), .DEPTH(DEPTH), .CW(PW+1)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_ready(a_ready), .a_io(a_io),
  .b_valid(b_valid), .b_ready(b_ready), .b_io(b_io),
  .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data),
  .m_tag(m_tag), .m_io(m_io), .sync_ack(sync_ack),
  .cnt0(cnt[0]), .cnt1(cnt[1])
);

// File: tb/sim_ordered_store_buffer.sv
module sim_ordered_store_buffer;
  localparam int AW = 16, DW = 16, SW = 6, DEPTH = 4, N = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_valid = 0, a_io = 0, b_valid = 0, b_io = 0, m_ready = 0, sync_req = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic [SW-1:0] a_seq = '0, b_seq = '0;
  logic a_ready, b_ready, m_valid, m_io, sync_ack;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [SW-1:0] m_tag;
  int vecs = 0, errs = 0;

  always #5 clk = ~clk;

  ordered_store_buffer #(.AW(AW), .DW(DW), .SW(SW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_addr(a_addr), .a_data(a_data), .a_seq(a_seq), .a_io(a_io),
    .b_valid(b_valid), .b_ready(b_ready), .b_addr(b_addr), .b_data(b_data), .b_seq(b_seq), .b_io(b_io),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data), .m_tag(m_tag), .m_io(m_io),
    .sync_req(sync_req), .sync_ack(sync_ack)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pipe_of(int k, int pm);
    case (pm)
      0: return 0;
      1: return 1;
      2: return k % 2;
      default: return ((k * 5) / 3) % 2;
    endcase
  endfunction

  function automatic bit io_of(int k, int im);
    return (im == 1) && (k % 5 == 3);
  endfunction

  function automatic bit rdy_of(int c, int rm);
    case (rm)
      0: return 1'b1;
      1: return c[0];
      default: return (c % 7) < 3;
    endcase
  endfunction

  function automatic logic [AW-1:0] addr_of(int k); return AW'(16'h1000 + k * 4); endfunction
  function automatic logic [DW-1:0] data_of(int k); return DW'(k * 16'h0101 + 7); endfunction

  task automatic drive(input int p, input int k, input bit isio);
    if (p == 0) begin
      a_valid = 1; a_seq = SW'(k); a_addr = addr_of(k); a_data = data_of(k); a_io = isio;
    end else begin
      b_valid = 1; b_seq = SW'(k); b_addr = addr_of(k); b_data = data_of(k); b_io = isio;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; a_valid = 0; b_valid = 0; a_io = 0; b_io = 0; m_ready = 0; sync_req = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run(input int pm, input int im, input int rm);
    bit acc [N];
    int out_n, cyc, i0, i1, ka, kb;
    out_n = 0; cyc = 0;
    for (int k = 0; k < N; k++) acc[k] = 0;
    do_reset();
    while (out_n < N && cyc < 3000) begin
      @(negedge clk);
      a_valid = 0; b_valid = 0; a_io = 0; b_io = 0;
      i0 = -1; i1 = -1; ka = -1; kb = -1;
      for (int k = 0; k < N; k++)
        if (!acc[k]) begin
          if (i0 < 0) i0 = k;
          else if (i1 < 0) i1 = k;
        end
      if (i0 >= 0) begin
        drive(pipe_of(i0, pm), i0, io_of(i0, im));
        if (pipe_of(i0, pm) == 0) ka = i0; else kb = i0;
      end
      if (i1 >= 0 && pipe_of(i1, pm) != pipe_of(i0, pm)) begin
        drive(pipe_of(i1, pm), i1, io_of(i1, im));
        if (pipe_of(i1, pm) == 0) ka = i1; else kb = i1;
      end
      m_ready = rdy_of(cyc, rm);
      #1;
      if (a_valid && a_ready) acc[ka] = 1;
      if (b_valid && b_ready) acc[kb] = 1;
      if (m_valid && m_ready) begin
        // R2 order and content, R4 I/O flag
        chk({m_tag, m_addr, m_data, m_io} == {SW'(out_n), addr_of(out_n), data_of(out_n), io_of(out_n, im)},
            "R2/R4 write order", {m_tag, m_addr, m_data, m_io},
            {SW'(out_n), addr_of(out_n), data_of(out_n), io_of(out_n, im)});
        out_n++;
      end
      cyc++;
    end
    chk(out_n == N, "R2 all writes delivered", out_n, N);
    @(negedge clk);
    a_valid = 0; b_valid = 0; sync_req = 1;
    #1;
    chk(sync_ack == 1 && m_valid == 0, "R6 ack when drained", {sync_ack, m_valid}, 2'b10);
    sync_req = 0;
  endtask

  initial begin
    int k, del;
    bit got;
    do_reset();
    @(negedge clk);
    #1;
    chk(m_valid == 0, "R1 port idle", m_valid, 0);
    chk(a_ready == 1 && b_ready == 1, "R1 ports ready", {a_ready, b_ready}, 2'b11);
    sync_req = 1;
    #1;
    chk(sync_ack == 1, "R6 ack on idle", sync_ack, 1);
    sync_req = 0;

    // R3: fill pipe A against a stalled port
    k = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      drive(0, k, 0);
      m_ready = 0;
      #1;
      if (a_ready) k++;
    end
    chk(k == DEPTH + 1, "R3 accepted before full", k, DEPTH + 1);
    chk(a_ready == 0, "R3 ready low when full", a_ready, 0);
    chk(m_valid == 1 && m_tag == 0, "R5 stalled write held", {m_valid, m_tag}, {1'b1, SW'(0)});
    // R4: I/O store on pipe B must wait while writes are buffered
    @(negedge clk);
    a_valid = 0;
    drive(1, k, 1);
    #1;
    chk(b_ready == 0, "R4 I/O held while buffered", b_ready, 0);
    b_valid = 0; b_io = 0;
    sync_req = 1;
    #1;
    chk(sync_ack == 0, "R6 no ack while buffered", sync_ack, 0);
    del = 0; got = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      m_ready = 1;
      #1;
      if (m_valid && m_ready) begin
        chk(m_tag == SW'(del), "R2 drain order", m_tag, del);
        del++;
      end
      if (sync_ack && !got) begin
        got = 1;
        chk(del == DEPTH + 1 && !m_valid, "R6 ack only after drain", del, DEPTH + 1);
      end
    end
    chk(got, "R6 ack seen", got, 1);
    sync_req = 0;

    for (int pm = 0; pm < 4; pm++)
      for (int im = 0; im < 2; im++)
        for (int rm = 0; rm < 3; rm++)
          run(pm, im, rm);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule